// File: doc/BRIEF.md
# Coprocessor Primitive Transfer Sequencer

This block sits on the main-processor side of a coprocessor interface. Each time a response primitive has been read from the coprocessor, the block takes the 16-bit primitive word together with the facts the processor holds about the current instruction: whether it is a conditional-category instruction, the F-line operation word, and the scan pointer. It recognises two primitives. The first copies the operation word into the coprocessor's operation-word register. The second moves a run of extension bytes from the instruction stream into the coprocessor's operand register.

For the instruction-stream primitive, the block asks a fetch port for 32-bit or 16-bit items at the scan pointer. It forwards each returned item to the register-write port and moves the scan pointer past it. Before any transfer starts, the block checks the primitive against the protocol rules. A breach gives a violation pulse, and nothing is moved. A primitive code the block does not handle gives an "unhandled" pulse, so the surrounding logic can process it. Every accepted primitive ends with exactly one single-cycle pulse.

Top module: `cpprim_seq`

## Requirements
- R1: After a synchronous reset, including a reset during a transfer, the block is idle: `prim_ready`=1, `fr_valid`=0, `wr_valid`=0, and no pulse output is high.
- R2: The primitive type is bits 13..8 of the primitive word. Code 6'b001111 is the instruction-stream transfer and code 6'b001100 is the operation-word transfer. Any other code gives an `unhandled` pulse with no fetch, no write and no change to `scan_out`.
- R3: The operation-word transfer makes exactly one write with `wr_sel`=0 (operation-word register), `wr_long`=0 and `wr_data`={16'h0, op_word}, then pulses `done`. `scan_out` stays equal to the `scan_in` given with the primitive.
- R4: For the instruction-stream transfer, bits 7..0 give the byte length L. The block fetches 32-bit items (`fr_long`=1) while 4 or more bytes remain, and then one 16-bit item (`fr_long`=0) if 2 remain. The first address is `scan_in`, and each later address is the previous one plus the previous item's size. Each item is written with `wr_sel`=1 (operand register) and the same `wr_long`. A 16-bit item is written as {16'h0, fd_data[15:0]}. At `done`, `scan_out` = `scan_in` + L.
- R5: An instruction-stream transfer with an odd L gives a `viol` pulse in the cycle after acceptance. It makes no fetch and no write, and `scan_out` is left at `scan_in`.
- R6: Either handled primitive with bit 15 (CA) = 0 while `cond_cat`=1 gives a `viol` pulse in the cycle after acceptance, with no fetch or write. With `cond_cat`=0, CA has no effect.
- R7: An instruction-stream transfer with L=0 pulses `done` in the cycle after acceptance, with no fetch, no write and `scan_out` equal to `scan_in`.
- R8: While `fr_valid` or `wr_valid` is high and its ready input is low, the valid stays high and the address, size, select and data stay stable. Back-pressure does not change the transferred data.
- R9: A primitive is accepted only on a cycle with `prim_valid` and `prim_ready` both high, and `prim_ready` is high only while idle. Each accepted primitive produces exactly one single-cycle pulse on one of `done`, `viol` or `unhandled`.
- R10: Bit 14 (PC) of the primitive word has no effect on the block's behaviour.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prim_valid | input | 1 | Primitive word offered |
| prim_ready | output | 1 | Block idle; primitive taken this cycle if valid |
| prim_word | input | 16 | Response primitive word |
| cond_cat | input | 1 | Current instruction is conditional category |
| op_word | input | 16 | Current F-line operation word |
| scan_in | input | AW | Scan pointer at primitive acceptance |
| scan_out | output | AW | Current scan pointer |
| fr_valid | output | 1 | Fetch request valid |
| fr_ready | input | 1 | Fetch request accepted |
| fr_addr | output | AW | Fetch address |
| fr_long | output | 1 | 1 = 32-bit item, 0 = 16-bit item |
| fd_valid | input | 1 | Fetch data returned |
| fd_data | input | 32 | Fetch data (16-bit items in the low half) |
| wr_valid | output | 1 | Coprocessor register write valid |
| wr_ready | input | 1 | Register write accepted |
| wr_sel | output | 1 | 0 = operation-word register, 1 = operand register |
| wr_long | output | 1 | 1 = 32-bit write, 0 = 16-bit write |
| wr_data | output | 32 | Write data |
| done | output | 1 | One-cycle completion pulse |
| viol | output | 1 | One-cycle protocol-violation pulse |
| unhandled | output | 1 | One-cycle pulse for an unrecognised primitive code |

## Verification
The instruction-stream transfer is run with lengths of 2, 6, 8, 10, 12 and 254 bytes. These separate a word-only transfer, a long-then-word mix, long-only runs and the longest even length, and each one exposes errors in item sizing, address stepping and the final scan pointer. The same transfers are repeated under alternating-cycle back-pressure on both the fetch and the write ports, so that data held across stalls is compared with the unstalled case. The legality patterns cross CA with the category for both primitives and add odd lengths 5 and 255, which shows whether a violation blocks all movement. An unknown code, a zero length, a flipped PC bit and a reset in the middle of a transfer cover the remaining branches.

// File: rtl/cpprim_pkg.sv
package cpprim_pkg;
  localparam int PRIM_W  = 16;
  localparam int CA_BIT  = 15;
  localparam int PC_BIT  = 14;
  localparam int TYPE_HI = 13;
  localparam int TYPE_LO = 8;
  localparam int TYPE_W  = TYPE_HI - TYPE_LO + 1;
  localparam int LEN_W   = 8;
  localparam int OPW_W   = 16;
  localparam int XFER_W  = 32;
  localparam int HALF_W  = XFER_W / 2;
  localparam int STEP_W  = 3;

  localparam logic [TYPE_W-1:0] CODE_ISTR = 6'b001111;
  localparam logic [TYPE_W-1:0] CODE_OPW  = 6'b001100;

  localparam logic SEL_OPW  = 1'b0;
  localparam logic SEL_OPND = 1'b1;

  typedef enum logic [1:0] {PK_OPW, PK_ISTR, PK_OTHER} prim_kind_e;
  typedef enum logic [1:0] {ST_IDLE, ST_FREQ, ST_FWAIT, ST_WRITE} seq_state_e;

  typedef struct packed {
    prim_kind_e       kind;
    logic [LEN_W-1:0] len;
    logic             illegal;
  } prim_dec_t;

  function automatic prim_dec_t decode_prim(input logic [PRIM_W-1:0] w,
                                            input logic cond);
    prim_dec_t d;
    logic [TYPE_W-1:0] code;
    code = w[TYPE_HI:TYPE_LO];
    d.len = w[LEN_W-1:0];
    if (code == CODE_ISTR)     d.kind = PK_ISTR;
    else if (code == CODE_OPW) d.kind = PK_OPW;
    else                       d.kind = PK_OTHER;
    d.illegal = 1'b0;
    if (d.kind != PK_OTHER && cond && !w[CA_BIT]) d.illegal = 1'b1;
    if (d.kind == PK_ISTR && d.len[0])            d.illegal = 1'b1;
    return d;
  endfunction
endpackage

// File: rtl/cpprim_decode.sv
module cpprim_decode
  import cpprim_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [PRIM_W-1:0] word,
  input  logic              cond_cat,
  output prim_dec_t         dec
);
  localparam logic [PRIM_W-1:0] PC_MASK = PRIM_W'(1) << PC_BIT;

  always_comb dec = decode_prim(word, cond_cat);

  // The PC flag must not reach any decoded field.
  always_ff @(posedge clk) begin
    if (!rst) begin
      assert_pc_ignored_R10: assert (decode_prim(word ^ PC_MASK, cond_cat) == dec)
        else $error("PC flag altered the decode");
    end
  end
endmodule

// File: rtl/cpprim_step.sv
module cpprim_step
  import cpprim_pkg::*;
#(
  parameter bit USE_LONG = 1'b1
) (
  input  logic [LEN_W-1:0]  remain,
  output logic              item_long,
  output logic [STEP_W-1:0] item_bytes
);
  localparam logic [LEN_W-1:0] LONG_BYTES = LEN_W'(4);

  generate
    if (USE_LONG) begin : g_long
      always_comb item_long = (remain >= LONG_BYTES);
    end else begin : g_word
      always_comb item_long = 1'b0;
    end
  endgenerate

  always_comb item_bytes = item_long ? STEP_W'(4) : STEP_W'(2);
endmodule

// File: rtl/cpprim_scan.sv
module cpprim_scan
  import cpprim_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [AW-1:0]     load_val,
  input  logic              adv,
  input  logic [STEP_W-1:0] adv_bytes,
  output logic [AW-1:0]     ptr
);
  always_ff @(posedge clk) begin
    if (rst)       ptr <= '0;
    else if (load) ptr <= load_val;
    else if (adv)  ptr <= ptr + AW'(adv_bytes);
  end

  // The pointer only moves on a load or a fetch handshake.
  assert_scan_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!load && !adv) |=> $stable(ptr));
endmodule

// File: rtl/cpprim_seq.sv
module cpprim_seq
  import cpprim_pkg::*;
#(
  parameter int AW       = 32,
  parameter bit USE_LONG = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              prim_valid,
  output logic              prim_ready,
  input  logic [PRIM_W-1:0] prim_word,
  input  logic              cond_cat,
  input  logic [OPW_W-1:0]  op_word,
  input  logic [AW-1:0]     scan_in,
  output logic [AW-1:0]     scan_out,
  output logic              fr_valid,
  input  logic              fr_ready,
  output logic [AW-1:0]     fr_addr,
  output logic              fr_long,
  input  logic              fd_valid,
  input  logic [XFER_W-1:0] fd_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic              wr_sel,
  output logic              wr_long,
  output logic [XFER_W-1:0] wr_data,
  output logic              done,
  output logic              viol,
  output logic              unhandled
);
  seq_state_e        st_q;
  prim_dec_t         dec;
  logic [LEN_W-1:0]  rem_q;
  logic              item_long;
  logic [STEP_W-1:0] item_bytes;
  logic              wlong_q, wsel_q;
  logic [XFER_W-1:0] wdata_q;
  logic              done_q, viol_q, unh_q;
  logic              accept, fetch_hs;

  cpprim_decode u_decode (
    .clk      (clk),
    .rst      (rst),
    .word     (prim_word),
    .cond_cat (cond_cat),
    .dec      (dec)
  );

  cpprim_step #(.USE_LONG(USE_LONG)) u_step (
    .remain     (rem_q),
    .item_long  (item_long),
    .item_bytes (item_bytes)
  );

  always_comb begin
    accept   = prim_valid && (st_q == ST_IDLE);
    fetch_hs = (st_q == ST_FREQ) && fr_ready;
  end

  cpprim_scan #(.AW(AW)) u_scan (
    .clk       (clk),
    .rst       (rst),
    .load      (accept),
    .load_val  (scan_in),
    .adv       (fetch_hs),
    .adv_bytes (item_bytes),
    .ptr       (scan_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      rem_q   <= '0;
      wlong_q <= 1'b0;
      wsel_q  <= SEL_OPW;
      wdata_q <= '0;
      done_q  <= 1'b0;
      viol_q  <= 1'b0;
      unh_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      viol_q <= 1'b0;
      unh_q  <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (accept) begin
            if (dec.illegal) begin
              viol_q <= 1'b1;
            end else begin
              unique case (dec.kind)
                PK_OPW: begin
                  st_q    <= ST_WRITE;
                  rem_q   <= '0;
                  wsel_q  <= SEL_OPW;
                  wlong_q <= 1'b0;
                  wdata_q <= {{(XFER_W-OPW_W){1'b0}}, op_word};
                end
                PK_ISTR: begin
                  if (dec.len == '0) begin
                    done_q <= 1'b1;
                  end else begin
                    st_q  <= ST_FREQ;
                    rem_q <= dec.len;
                  end
                end
                default: unh_q <= 1'b1;
              endcase
            end
          end
        end
        ST_FREQ: begin
          if (fr_ready) begin
            st_q    <= ST_FWAIT;
            rem_q   <= rem_q - LEN_W'(item_bytes);
            wlong_q <= item_long;
            wsel_q  <= SEL_OPND;
          end
        end
        ST_FWAIT: begin
          if (fd_valid) begin
            st_q    <= ST_WRITE;
            wdata_q <= wlong_q ? fd_data
                               : {{(XFER_W-HALF_W){1'b0}}, fd_data[HALF_W-1:0]};
          end
        end
        ST_WRITE: begin
          if (wr_ready) begin
            if (rem_q == '0) begin
              st_q   <= ST_IDLE;
              done_q <= 1'b1;
            end else begin
              st_q <= ST_FREQ;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    prim_ready = (st_q == ST_IDLE);
    fr_valid   = (st_q == ST_FREQ);
    fr_addr    = scan_out;
    fr_long    = item_long;
    wr_valid   = (st_q == ST_WRITE);
    wr_sel     = wsel_q;
    wr_long    = wlong_q;
    wr_data    = wdata_q;
    done       = done_q;
    viol       = viol_q;
    unhandled  = unh_q;
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    prim_ready |-> (!fr_valid && !wr_valid));

  assert_fetch_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (fr_valid && !fr_ready) |=> (fr_valid && $stable(fr_addr) && $stable(fr_long)));

  assert_write_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !wr_ready) |=>
      (wr_valid && $stable(wr_data) && $stable(wr_sel) && $stable(wr_long)));

  assert_one_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({done, viol, unhandled}));

  assert_odd_len_R5: assert property (@(posedge clk) disable iff (rst)
    (prim_valid && prim_ready && prim_word[TYPE_HI:TYPE_LO] == CODE_ISTR
     && prim_word[0]) |=> (viol && !fr_valid && !wr_valid));

  assert_ca_cond_R6: assert property (@(posedge clk) disable iff (rst)
    (prim_valid && prim_ready && cond_cat && !prim_word[CA_BIT]
     && (prim_word[TYPE_HI:TYPE_LO] == CODE_ISTR
         || prim_word[TYPE_HI:TYPE_LO] == CODE_OPW)) |=> viol);
endmodule

// File: tb/cpprim_seq_tb.sv
module cpprim_seq_tb;
  localparam int AW = 32;
  localparam logic [1:0] K_DONE = 2'd0, K_VIOL = 2'd1, K_UNH = 2'd2;
  localparam int NVEC = 11;
  // {prim[15:0], cond, stall, scan[31:0], expected kind[1:0]}
  localparam logic [51:0] VEC [NVEC] = '{
    {16'h8F08, 1'b0, 1'b0, 32'h0000_1000, K_DONE},
    {16'h8F06, 1'b0, 1'b1, 32'h0000_2002, K_DONE},
    {16'h8F02, 1'b1, 1'b0, 32'h0000_3000, K_DONE},
    {16'h0F04, 1'b1, 1'b0, 32'h0000_4000, K_VIOL},
    {16'h8F05, 1'b0, 1'b0, 32'h0000_5000, K_VIOL},
    {16'h8C00, 1'b0, 1'b0, 32'h0000_6000, K_DONE},
    {16'h0C00, 1'b1, 1'b0, 32'h0000_7000, K_VIOL},
    {16'h8C00, 1'b1, 1'b1, 32'h0000_8000, K_DONE},
    {16'h8500, 1'b0, 1'b0, 32'h0000_9000, K_UNH},
    {16'h0F0C, 1'b0, 1'b1, 32'h0000_A004, K_DONE},
    {16'h8F0A, 1'b0, 1'b1, 32'h0000_B000, K_DONE}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic prim_valid = 1'b0, cond_cat = 1'b0;
  logic [15:0] prim_word = '0, op_word = '0;
  logic [AW-1:0] scan_in = '0;
  logic fr_ready = 1'b0, fd_valid = 1'b0, wr_ready = 1'b0;
  logic [31:0] fd_data = '0;
  logic prim_ready, fr_valid, fr_long, wr_valid, wr_sel, wr_long;
  logic done, viol, unhandled;
  logic [AW-1:0] scan_out, fr_addr;
  logic [31:0] wr_data;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  cpprim_seq #(.AW(AW)) u_dut (
    .clk(clk), .rst(rst), .prim_valid(prim_valid), .prim_ready(prim_ready),
    .prim_word(prim_word), .cond_cat(cond_cat), .op_word(op_word),
    .scan_in(scan_in), .scan_out(scan_out), .fr_valid(fr_valid),
    .fr_ready(fr_ready), .fr_addr(fr_addr), .fr_long(fr_long),
    .fd_valid(fd_valid), .fd_data(fd_data), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_sel(wr_sel), .wr_long(wr_long),
    .wr_data(wr_data), .done(done), .viol(viol), .unhandled(unhandled)
  );

  function automatic logic [7:0] mem_byte(input logic [AW-1:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  function automatic logic [31:0] mem_item(input logic [AW-1:0] a, input logic lng);
    if (lng) return {mem_byte(a), mem_byte(a + 1), mem_byte(a + 2), mem_byte(a + 3)};
    return {16'h0000, mem_byte(a), mem_byte(a + 1)};
  endfunction

  task automatic check(input logic ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Offer one primitive, serve fetches and writes, then check the outcome.
  task automatic run_prim(input logic [15:0] p, input logic c, input logic stall,
                          input logic [AW-1:0] s, input logic [1:0] ek,
                          input string tag);
    int cyc, nwrite, bytes, exp_writes, exp_bytes, rem, pend_wait;
    logic fin, pend, tog, busy_bad, tow, istr;
    logic [1:0] got;
    logic [AW-1:0] exp_addr, cur_addr;
    logic cur_long;
    logic [15:0] opw;
    string dtag;
    opw = 16'hA55A ^ p;
    tow = (p[13:8] == 6'b001100);
    istr = (p[13:8] == 6'b001111);
    dtag = stall ? "R8" : (tow ? "R3" : "R4");
    exp_writes = 0; exp_bytes = 0;
    if (ek == K_DONE && tow) exp_writes = 1;
    if (ek == K_DONE && istr) begin
      exp_bytes = int'(p[7:0]);
      exp_writes = exp_bytes / 4 + ((exp_bytes % 4) != 0 ? 1 : 0);
    end
    @(negedge clk);
    prim_valid = 1'b1; prim_word = p; cond_cat = c; scan_in = s; op_word = opw;
    @(negedge clk);
    prim_valid = 1'b0;
    fin = 1'b0; pend = 1'b0; tog = 1'b0; busy_bad = 1'b0; pend_wait = 0;
    cyc = 0; nwrite = 0; bytes = 0; rem = int'(p[7:0]); exp_addr = s;
    cur_addr = '0; cur_long = 1'b0; got = 2'd3;
    while (!fin && cyc < 800) begin
      fd_valid = 1'b0; fr_ready = 1'b0; wr_ready = 1'b0; fd_data = 32'hFFFF_FFFF;
      if (pend) begin
        if (pend_wait == 0) begin
          fd_valid = 1'b1;
          fd_data = cur_long ? mem_item(cur_addr, 1'b1)
                             : {16'hDEAD, mem_item(cur_addr, 1'b0)};
          pend = 1'b0;
        end else pend_wait--;
      end
      if (fr_valid) begin
        check(fr_addr == exp_addr, dtag, "fetch address", 64'(fr_addr), 64'(exp_addr));
        check(fr_long == (rem >= 4), dtag, "fetch size", 64'(fr_long), 64'(rem >= 4));
        if (!stall || tog) begin
          fr_ready = 1'b1; cur_addr = fr_addr; cur_long = fr_long;
          pend = 1'b1; pend_wait = stall ? 1 : 0;
          exp_addr = exp_addr + (fr_long ? 4 : 2);
          rem = rem - (fr_long ? 4 : 2);
        end
      end
      if (wr_valid) begin
        if (tow) begin
          check(wr_sel == 1'b0 && wr_long == 1'b0 && wr_data == {16'h0, opw},
                dtag, "op-word write", 64'({wr_sel, wr_long, wr_data}),
                64'({2'b00, 16'h0, opw}));
        end else begin
          check(wr_sel == 1'b1 && wr_long == cur_long
                && wr_data == mem_item(cur_addr, cur_long), dtag, "operand write",
                64'({wr_sel, wr_long, wr_data}),
                64'({1'b1, cur_long, mem_item(cur_addr, cur_long)}));
        end
        if (!stall || tog) begin
          wr_ready = 1'b1; nwrite++;
          if (!tow) bytes += (wr_long ? 4 : 2);
        end
      end
      if (done || viol || unhandled) begin
        fin = 1'b1;
        got = done ? K_DONE : (viol ? K_VIOL : K_UNH);
        check(32'(done) + 32'(viol) + 32'(unhandled) == 1, "R9", "pulse count",
              64'({done, viol, unhandled}), 64'd1);
      end else if (prim_ready) busy_bad = 1'b1;
      tog = ~tog; cyc++;
      @(negedge clk);
    end
    fr_ready = 1'b0; wr_ready = 1'b0; fd_valid = 1'b0;
    check(fin, tag, "primitive finished", 64'(fin), 64'd1);
    check(got == ek, tag, "outcome", 64'(got), 64'(ek));
    check(nwrite == exp_writes, tag, "write count", 64'(nwrite), 64'(exp_writes));
    check(bytes == exp_bytes, tag, "bytes moved", 64'(bytes), 64'(exp_bytes));
    check(scan_out == s + AW'(exp_bytes), tag, "scan pointer", 64'(scan_out),
          64'(s + AW'(exp_bytes)));
    check(!busy_bad, "R9", "prim_ready low while busy", 64'(busy_bad), 64'd0);
    check(!done && !viol && !unhandled, "R9", "pulse one cycle",
          64'({done, viol, unhandled}), 64'd0);
  endtask

  function automatic string vec_tag(input int i);
    case (i)
      3, 6:    return "R6";
      4:       return "R5";
      5, 7:    return "R3";
      8:       return "R2";
      10:      return "R10";
      1, 9:    return "R8";
      default: return "R4";
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(prim_ready && !fr_valid && !wr_valid && !done && !viol && !unhandled,
          "R1", "idle after reset",
          64'({prim_ready, fr_valid, wr_valid, done, viol, unhandled}), 64'h20);

    for (int i = 0; i < NVEC; i++) begin
      run_prim(VEC[i][51:36], VEC[i][35], VEC[i][34], VEC[i][33:2], VEC[i][1:0],
               vec_tag(i));
    end

    run_prim(16'h8F00, 1'b0, 1'b0, 32'h0000_C000, K_DONE, "R7");
    run_prim(16'h8FFE, 1'b0, 1'b0, 32'h0001_0000, K_DONE, "R4");
    run_prim(16'h8FFF, 1'b0, 1'b0, 32'h0001_2000, K_VIOL, "R5");
    run_prim(16'h4F0A, 1'b0, 1'b0, 32'h0000_B000, K_DONE, "R10");
    run_prim(16'h0F04, 1'b0, 1'b0, 32'h0000_D000, K_DONE, "R6");

    // Reset in the middle of a transfer.
    @(negedge clk);
    prim_valid = 1'b1; prim_word = 16'h8F08; cond_cat = 1'b0; scan_in = 32'h0000_E000;
    @(negedge clk);
    prim_valid = 1'b0;
    check(fr_valid && !prim_ready, "R9", "busy after accept",
          64'({fr_valid, prim_ready}), 64'h2);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(prim_ready && !fr_valid && !wr_valid && !done && !viol && !unhandled,
          "R1", "idle after mid-transfer reset",
          64'({prim_ready, fr_valid, wr_valid, done, viol, unhandled}), 64'h20);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule